// File: doc/BRIEF.md
# Serial span-and-code receiver for a programmable-range DAC

This block is the digital front end of a 16-bit DAC whose output range can be changed at run time. A host drives three wires: an active-low select that also acts as the load strobe, a serial clock and a data line. While the select is low, the block collects a frame, most significant bit first. The last 24 bits collected hold a 4-bit command in the top nibble, then 4 reserved bits, then a 16-bit code. When the select returns high, the block decodes the command. In the same system-clock cycle it updates the stored output span, the stored code, or both.

A host may send the short 24-bit form. It may also send a 32-bit form, which puts 8 filler bits in front of the payload. The serial output repeats the input stream delayed by exactly 32 serial clocks, so a chain of receivers can share one data line only when every frame is 32 bits long. A parameter narrows the code to 12 or 14 bits. The narrow code stays left-justified in the 16-bit data field, and the low field bits are ignored. All three serial inputs are taken to be synchronous to the block clock, which must run well above the serial clock.

Top module: `sdac_rx`

## Requirements
- R1: After reset, span_sel is 0 (the 0 to 5 V range), dac_code is all zeros and sdo is 0.
- R2: A serial bit is taken on a rising sck edge while cs_ld is low. Decoding uses the last 24 bits taken: bits 23..20 are the command, bits 19..16 are ignored, and bits 15..0 are the code field.
- R3: On a load, command 1001 sets span_sel to 1 (0 to 10 V), command 1010 sets it to 2 (±5 V) and command 1011 sets it to 3 (±10 V). Each of these commands also loads the code field. The remaining span encodings are 0 for 0 to 5 V, 4 for ±2.5 V and 5 for 2.5 to 7.5 V.
- R4: On a load, command 0010 writes only dac_code and leaves span_sel unchanged.
- R5: On a load, any other command leaves both span_sel and dac_code unchanged.
- R6: In a 32-bit frame, the 8 leading bits have no effect on the result.
- R7: sdo changes only on a falling sck edge while cs_ld is low. It then takes the bit that entered 32 rising edges earlier, so during a 32-bit frame it replays the previous 32-bit frame MSB first.
- R8: sck edges while cs_ld is high change neither the collected bits nor sdo, span_sel or dac_code.
- R9: span_sel and dac_code change only in the clock cycle in which cs_ld is first sampled high, and they change together, one clock edge after the rise.
- R10: With CODE_BITS below 16, dac_code equals the code-field bits 15 down to 16-CODE_BITS.
- R11: A rising sck edge sampled in the same cycle as the cs_ld rise is ignored. The load uses the bits collected before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_ld | input | 1 | Active-low select; its rising edge loads the frame |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, delayed by 32 sck edges |
| span_sel | output | 3 | Active output-range code |
| dac_code | output | CODE_BITS | Active DAC code |

## Verification
The load strobe and a serial clock edge can land in the same block-clock cycle. The bench provokes this by raising sck on the final bit in the very cycle that cs_ld goes high. It judges the result from the loaded span and code: those must decode from the 24 bits taken before that edge. A frame shifted by one more bit would decode to an undefined command and leave the old values in place. A second instance built with 12-bit width runs the same vectors, so the narrowing is judged in the same cycles as the full-width load.

// File: rtl/sdac_rx_pkg.sv
`timescale 1ns/1ps
package sdac_rx_pkg;

  localparam int unsigned WORD_BITS  = 16;
  localparam int unsigned CMD_BITS   = 4;
  localparam int unsigned CHAIN_BITS = 32;

  typedef enum logic [2:0] {
    SPAN_U5   = 3'd0,
    SPAN_U10  = 3'd1,
    SPAN_B5   = 3'd2,
    SPAN_B10  = 3'd3,
    SPAN_B2P5 = 3'd4,
    SPAN_OFS  = 3'd5
  } span_e;

  localparam logic [3:0] CMD_SET_U10 = 4'b1001;
  localparam logic [3:0] CMD_SET_B5  = 4'b1010;
  localparam logic [3:0] CMD_SET_B10 = 4'b1011;
  localparam logic [3:0] CMD_CODE    = 4'b0010;

  // true when the command rewrites the output range
  function automatic logic cmd_sets_span(logic [CMD_BITS-1:0] c);
    return (c == CMD_SET_U10) || (c == CMD_SET_B5) || (c == CMD_SET_B10);
  endfunction

  // true when the command rewrites the code register
  function automatic logic cmd_sets_code(logic [CMD_BITS-1:0] c);
    return cmd_sets_span(c) || (c == CMD_CODE);
  endfunction

  function automatic span_e span_for(logic [CMD_BITS-1:0] c, span_e keep);
    span_e s;
    case (c)
      CMD_SET_U10: s = SPAN_U10;
      CMD_SET_B5:  s = SPAN_B5;
      CMD_SET_B10: s = SPAN_B10;
      default:     s = keep;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sdac_rx_edge.sv
`timescale 1ns/1ps
module sdac_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_ld,
  input  logic sck,
  output logic sck_rise,
  output logic sck_fall,
  output logic load_evt
);

  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_ld;
    end
  end

  // serial edges count only while the select is low in this very sample
  assign sck_rise = sck & ~sck_q & ~cs_ld;
  assign sck_fall = ~sck & sck_q & ~cs_ld;
  assign load_evt = cs_ld & ~cs_q;

endmodule

// File: rtl/sdac_rx_shift.sv
`timescale 1ns/1ps
module sdac_rx_shift
  import sdac_rx_pkg::*;
#(
  parameter int unsigned DEPTH = CHAIN_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  drain_en,
  input  logic                  sdi,
  output logic [CMD_BITS-1:0]   cmd_bits,
  output logic [WORD_BITS-1:0]  data_bits,
  output logic                  chain_msb,
  output logic                  sdo
);

  localparam int unsigned CMD_LSB = WORD_BITS + 4;

  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= {sh_q[DEPTH-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo <= 1'b0;
    end else if (drain_en) begin
      sdo <= sh_q[DEPTH-1];
    end
  end

  assign chain_msb = sh_q[DEPTH-1];
  assign cmd_bits  = sh_q[CMD_LSB +: CMD_BITS];
  assign data_bits = sh_q[WORD_BITS-1:0];

endmodule

// File: rtl/sdac_rx_decode.sv
`timescale 1ns/1ps
module sdac_rx_decode
  import sdac_rx_pkg::*;
(
  input  logic [CMD_BITS-1:0] cmd,
  input  span_e               cur_span,
  output span_e               span_nxt,
  output logic                span_wr,
  output logic                code_wr
);

  always_comb begin
    span_wr  = cmd_sets_span(cmd);
    code_wr  = cmd_sets_code(cmd);
    span_nxt = span_for(cmd, cur_span);
  end

endmodule

// File: rtl/sdac_rx.sv
`timescale 1ns/1ps
module sdac_rx
  import sdac_rx_pkg::*;
#(
  parameter int unsigned CODE_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_ld,
  input  logic                 sck,
  input  logic                 sdi,
  output logic                 sdo,
  output logic [2:0]           span_sel,
  output logic [CODE_BITS-1:0] dac_code
);

  localparam int unsigned DROP_BITS = WORD_BITS - CODE_BITS;

  logic                 sck_rise;
  logic                 sck_fall;
  logic                 load_evt;
  logic [CMD_BITS-1:0]  cmd_bits;
  logic [WORD_BITS-1:0] data_bits;
  logic                 chain_msb;
  logic                 span_wr;
  logic                 code_wr;
  logic                 cmd_known;
  span_e                span_q;
  span_e                span_nxt;
  logic [CODE_BITS-1:0] code_q;
  logic [CODE_BITS-1:0] code_field;

  sdac_rx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_ld    (cs_ld),
    .sck      (sck),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .load_evt (load_evt)
  );

  sdac_rx_shift #(.DEPTH(CHAIN_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (sck_rise),
    .drain_en  (sck_fall),
    .sdi       (sdi),
    .cmd_bits  (cmd_bits),
    .data_bits (data_bits),
    .chain_msb (chain_msb),
    .sdo       (sdo)
  );

  sdac_rx_decode u_dec (
    .cmd      (cmd_bits),
    .cur_span (span_q),
    .span_nxt (span_nxt),
    .span_wr  (span_wr),
    .code_wr  (code_wr)
  );

  assign cmd_known = code_wr;

  generate
    if (DROP_BITS == 0) begin : g_full
      assign code_field = data_bits;
    end else begin : g_narrow
      assign code_field = data_bits[WORD_BITS-1 -: CODE_BITS];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= SPAN_U5;
      code_q <= '0;
    end else if (load_evt) begin
      if (span_wr) span_q <= span_nxt;
      if (code_wr) code_q <= code_field;
    end
  end

  assign span_sel = span_q;
  assign dac_code = code_q;

endmodule

// File: rtl/sdac_rx_chk.sv
`timescale 1ns/1ps
module sdac_rx_chk #(
  parameter int unsigned CODE_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_ld,
  input logic                 load_evt,
  input logic                 sck_fall,
  input logic [3:0]           cmd_bits,
  input logic                 cmd_known,
  input logic                 chain_msb,
  input logic                 sdo,
  input logic [2:0]           span_sel,
  input logic [CODE_BITS-1:0] dac_code
);

  a_r9_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(span_sel) && $stable(dac_code)));

  a_r8_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    cs_ld |=> ($stable(sdo) && $stable(chain_msb) && $stable(cmd_bits)));

  a_r4_code_keeps_span: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cmd_bits == 4'b0010) |=> $stable(span_sel));

  a_r5_unknown_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !cmd_known) |=> ($stable(span_sel) && $stable(dac_code)));

  a_r3_span_b10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cmd_bits == 4'b1011) |=> (span_sel == 3'd3));

  a_r3_span_u10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cmd_bits == 4'b1001) |=> (span_sel == 3'd1));

  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |=> (sdo == $past(chain_msb)));

endmodule

bind sdac_rx sdac_rx_chk #(.CODE_BITS(CODE_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_ld     (cs_ld),
  .load_evt  (load_evt),
  .sck_fall  (sck_fall),
  .cmd_bits  (cmd_bits),
  .cmd_known (cmd_known),
  .chain_msb (chain_msb),
  .sdo       (sdo),
  .span_sel  (span_sel),
  .dac_code  (dac_code)
);

// File: tb/test_sdac_rx.sv
`timescale 1ns/1ps
module test_sdac_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_ld = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_n12;
  logic [2:0]  span_sel, span_n12;
  logic [15:0] dac_code;
  logic [11:0] code_n12;
  logic [31:0] cap_word = '0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sdac_rx i_sdac_rx (
    .clk(clk), .rst_n(rst_n), .cs_ld(cs_ld), .sck(sck), .sdi(sdi),
    .sdo(sdo), .span_sel(span_sel), .dac_code(dac_code)
  );

  sdac_rx #(.CODE_BITS(12)) i_sdac_rx_n12 (
    .clk(clk), .rst_n(rst_n), .cs_ld(cs_ld), .sck(sck), .sdi(sdi),
    .sdo(sdo_n12), .span_sel(span_n12), .dac_code(code_n12)
  );

  // {long frame, frame bits, expected span, expected 16-bit code}
  localparam logic [51:0] VEC [8] = '{
    {1'b0, 32'h009F1234, 3'd1, 16'h1234},  // R2 R3: reserved bits set, ignored
    {1'b0, 32'h00A58000, 3'd2, 16'h8000},  // R3
    {1'b1, 32'hFFB3C000, 3'd3, 16'hC000},  // R3 R6: filler ones ignored
    {1'b1, 32'h002F4000, 3'd3, 16'h4000},  // R4 R6
    {1'b0, 32'h007AABCD, 3'd3, 16'h4000},  // R5
    {1'b0, 32'h00F0FFFF, 3'd3, 16'h4000},  // R5
    {1'b0, 32'h0020FFFF, 3'd3, 16'hFFFF},  // R4
    {1'b0, 32'h009000A5, 3'd1, 16'h00A5}   // R3
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    cap_word = {cap_word[30:0], sdo};
    sdi = b;
    sck = 1'b1;
    tick(2);
    sck = 1'b0;
    tick(2);
  endtask

  task automatic send_frame(logic [31:0] w, int n);
    cs_ld = 1'b0;
    tick(2);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    cs_ld = 1'b1;
    tick(3);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(span_sel == 3'd0, "R1 span", 32'(span_sel), 0);
    chk(dac_code == 16'h0, "R1 code", 32'(dac_code), 0);
    chk(sdo == 1'b0, "R1 sdo", 32'(sdo), 0);

    for (int v = 0; v < 8; v++) begin
      logic [51:0] e;
      e = VEC[v];
      send_frame(e[50:19], e[51] ? 32 : 24);
      chk(span_sel == e[18:16], "R3 R4 R5 span", 32'(span_sel), 32'(e[18:16]));
      chk(dac_code == e[15:0], "R2 R6 code", 32'(dac_code), 32'(e[15:0]));
      chk(code_n12 == (e[15:0] >> 4), "R10 narrow code", 32'(code_n12),
          32'(e[15:0] >> 4));
    end

    // R9: outputs stay put while a frame is shifting in
    cs_ld = 1'b0;
    tick(2);
    for (int i = 23; i >= 0; i--) send_bit(~i[0]);
    chk(dac_code == 16'h00A5, "R9 no early update", 32'(dac_code), 32'h00A5);
    cs_ld = 1'b1;
    tick(3);

    // R11: last sck rise coincides with the load strobe
    cs_ld = 1'b0;
    tick(2);
    for (int i = 23; i >= 0; i--) send_bit(logic'(24'hA01234 >> i));
    sdi = 1'b1;
    sck = 1'b1;
    cs_ld = 1'b1;
    tick(2);
    sck = 1'b0;
    tick(3);
    chk(span_sel == 3'd2, "R11 span", 32'(span_sel), 2);
    chk(dac_code == 16'h1234, "R11 code", 32'(dac_code), 32'h1234);

    // R7 R8: daisy-chain replay and idle clocks
    send_frame(32'h129F0ABC, 32);
    for (int i = 0; i < 10; i++) begin
      sdi = 1'b1; sck = 1'b1; tick(2);
      sck = 1'b0; tick(2);
    end
    chk(span_sel == 3'd1, "R8 span idle", 32'(span_sel), 1);
    chk(dac_code == 16'h0ABC, "R8 code idle", 32'(dac_code), 32'h0ABC);
    send_frame(32'h00A08000, 32);
    chk(cap_word == 32'h129F0ABC, "R7 R8 sdo replay", cap_word, 32'h129F0ABC);
    send_frame(32'h55201111, 32);
    chk(cap_word == 32'h00A08000, "R7 sdo replay", cap_word, 32'h00A08000);
    chk(span_sel == 3'd2, "R4 span kept", 32'(span_sel), 2);
    chk(dac_code == 16'h1111, "R4 code", 32'(dac_code), 32'h1111);

    // R1: reset after activity
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
    chk(span_sel == 3'd0, "R1 span again", 32'(span_sel), 0);
    chk(dac_code == 16'h0, "R1 code again", 32'(dac_code), 0);
    chk(code_n12 == 12'h0, "R1 narrow code", 32'(code_n12), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule